// File: doc/BRIEF.md
# Hierarchical Partial Barrier Unit

This block lets groups of cores meet at a common point without spinning on shared memory. Each core signals arrival with a one-cycle request that carries a two-bit scope code: its own tile, its own subgroup (several tiles), or the whole cluster. After signalling, the core is expected to sleep until woken. For every instance of every scope there is a private arrival counter. Once that counter holds the full participant count of its instance, the block raises a wake line to exactly the cores of that instance for one cycle and restarts the counter.

Arrival requests are plain control pulses. There is no ready signal and no back-pressure: every request with a valid scope code is taken in the cycle it is presented, however many cores raise one together. The geometry (cores per tile, tiles per subgroup, subgroups per cluster) is set by parameters. The defaults describe a 16-core model of a much larger machine.

Top module: `hier_barrier`

## Requirements
- R1: After reset all wake outputs are low and every arrival counter is empty.
- R2: Scope code 0 selects the tile. When all cores of a tile have arrived with code 0, the wake lines of that tile's cores are high in the cycle after the clock edge that sampled the last arrival.
- R3: Scope code 1 selects the subgroup. A subgroup completes once all of its cores (CORES_PER_TILE × TILES_PER_SG) have arrived with code 1, with the same one-cycle delay.
- R4: Scope code 2 selects the cluster. It completes once every core has arrived with code 2, with the same one-cycle delay.
- R5: A wake reaches only the cores of the completed instance. Cores of other tiles or subgroups stay low.
- R6: A wake lasts exactly one cycle.
- R7: Arrivals presented in the same cycle to the same counter are all counted.
- R8: An arrival presented in the cycle a counter's wake is high is counted toward that counter's next round.
- R9: Scope code 3 is reserved. An arrival carrying it changes no counter.
- R10: After a wake the counter restarts from zero, so an instance can be reused for any number of rounds. A counter never holds more than its participant total.
- R11: Counters of different instances and different scopes are independent. Mixed arrivals in one cycle each advance only their own counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | NCORE | Per-core one-cycle arrival request |
| arr_scope | input | 2*NCORE | Per-core scope code; bits [2i+1:2i] belong to core i |
| wake | output | NCORE | Per-core one-cycle wake pulse |

## Verification
Two events can meet on one counter in the same cycle: the counter clearing after a completed round, and a fresh arrival for that counter. The bench provokes this by completing a tile and, while the tile's wake is high, presenting a new tile-scope arrival from one of its cores. It then supplies only the remaining cores of the new round. A wake after exactly those remaining arrivals shows that the overlapping arrival was kept and not lost in the clear. Simultaneous arrivals from many cores to one counter are also mixed with arrivals to other scopes in the same cycle, and a reference model in the scoreboard judges every resulting wake vector.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
  typedef enum logic [1:0] {
    SC_TILE    = 2'd0,
    SC_SUBGRP  = 2'd1,
    SC_CLUSTER = 2'd2,
    SC_NONE    = 2'd3
  } scope_e;
endpackage

// File: rtl/hpb_tally.sv
module hpb_tally #(
  parameter int N = 4,
  localparam int W = $clog2(N + 1)
) (
  input  logic [N-1:0] hit,
  output logic [W-1:0] sum
);
  always_comb begin
    sum = '0;
    for (int i = 0; i < N; i++) sum = sum + W'(hit[i]);
  end
endmodule

// File: rtl/hpb_counter.sv
module hpb_counter #(
  parameter int TOTAL = 4,
  localparam int CW = $clog2(TOTAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] inc,
  output logic          done
);
  logic [CW-1:0] cnt;

  assign done = (cnt == CW'(TOTAL));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (done) cnt <= inc;        // restart; same-cycle arrivals join next round
    else           cnt <= cnt + inc;
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TOTAL));

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_needs_arrival_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(inc) != '0);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && inc == '0) |=> $stable(cnt));
endmodule

// File: rtl/hier_barrier.sv
module hier_barrier
  import hpb_pkg::*;
#(
  parameter int CORES_PER_TILE = 4,
  parameter int TILES_PER_SG   = 2,
  parameter int SG_COUNT       = 2,
  localparam int CPS   = CORES_PER_TILE * TILES_PER_SG,
  localparam int NCORE = CPS * SG_COUNT,
  localparam int NTILE = TILES_PER_SG * SG_COUNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCORE-1:0]   arr_valid,
  input  logic [2*NCORE-1:0] arr_scope,
  output logic [NCORE-1:0]   wake
);
  localparam int TW = $clog2(CORES_PER_TILE + 1);
  localparam int SW = $clog2(CPS + 1);
  localparam int CW = $clog2(NCORE + 1);

  logic [NCORE-1:0]    hit_t, hit_s, hit_c;
  logic [NTILE-1:0]    tile_done;
  logic [SG_COUNT-1:0] sg_done;
  logic                cl_done;

  for (genvar i = 0; i < NCORE; i++) begin : g_dec
    scope_e sc;
    assign sc       = scope_e'(arr_scope[2*i +: 2]);
    assign hit_t[i] = arr_valid[i] && (sc == SC_TILE);
    assign hit_s[i] = arr_valid[i] && (sc == SC_SUBGRP);
    assign hit_c[i] = arr_valid[i] && (sc == SC_CLUSTER);
  end

  for (genvar t = 0; t < NTILE; t++) begin : g_tile
    logic [TW-1:0] inc;
    hpb_tally #(.N(CORES_PER_TILE)) u_tally (
      .hit(hit_t[t*CORES_PER_TILE +: CORES_PER_TILE]), .sum(inc));
    hpb_counter #(.TOTAL(CORES_PER_TILE)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc), .done(tile_done[t]));
  end

  for (genvar s = 0; s < SG_COUNT; s++) begin : g_sg
    logic [SW-1:0] inc;
    hpb_tally #(.N(CPS)) u_tally (.hit(hit_s[s*CPS +: CPS]), .sum(inc));
    hpb_counter #(.TOTAL(CPS)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc), .done(sg_done[s]));
  end

  logic [CW-1:0] cl_inc;
  hpb_tally #(.N(NCORE)) u_cl_tally (.hit(hit_c), .sum(cl_inc));
  hpb_counter #(.TOTAL(NCORE)) u_cl_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cl_inc), .done(cl_done));

  for (genvar i = 0; i < NCORE; i++) begin : g_wake
    assign wake[i] = tile_done[i / CORES_PER_TILE] | sg_done[i / CPS] | cl_done;
  end

  // R9
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid != '0 && (hit_t | hit_s | hit_c) == '0) |=> !cl_done || $past(cl_done));
endmodule

// File: tb/hier_barrier_test.sv
module hier_barrier_test;
  localparam int CPT = 4, TPS = 2, SGN = 2;
  localparam int CPS = CPT * TPS, NC = CPS * SGN, NT = TPS * SGN;

  logic clk = 0, rst_n = 0;
  logic [NC-1:0]   arr_valid = '0;
  logic [2*NC-1:0] arr_scope = '0;
  logic [NC-1:0]   wake;

  always #2.5 clk = ~clk;

  hier_barrier #(.CORES_PER_TILE(CPT), .TILES_PER_SG(TPS), .SG_COUNT(SGN)) uut (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_scope(arr_scope), .wake(wake));

  typedef struct { logic [NC-1:0] w; string tag; } exp_t;
  exp_t q[$];
  int vectors = 0, bad = 0;
  int tc[NT], sc[SGN], cc;
  bit finished = 0;

  // monitor: scoreboard comparison just after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      vectors++;
      if (wake !== it.w) begin
        bad++;
        $display("FAIL %s wake=%h expected=%h", it.tag, wake, it.w);
      end
    end
  end

  // driver: applies one cycle and predicts wake after the next edge
  task automatic step(input logic [NC-1:0] v, input logic [2*NC-1:0] s, input string tag);
    int ti[NT], si[SGN], ci;
    exp_t it;
    @(negedge clk);
    arr_valid = v; arr_scope = s;
    ci = 0;
    for (int t = 0; t < NT; t++) ti[t] = 0;
    for (int g = 0; g < SGN; g++) si[g] = 0;
    for (int i = 0; i < NC; i++)
      if (v[i]) case (s[2*i +: 2])
        2'd0: ti[i / CPT]++;
        2'd1: si[i / CPS]++;
        2'd2: ci++;
        default: ;
      endcase
    for (int t = 0; t < NT; t++) tc[t] = (tc[t] == CPT) ? ti[t] : tc[t] + ti[t];
    for (int g = 0; g < SGN; g++) sc[g] = (sc[g] == CPS) ? si[g] : sc[g] + si[g];
    cc = (cc == NC) ? ci : cc + ci;
    for (int i = 0; i < NC; i++)
      it.w[i] = (tc[i / CPT] == CPT) || (sc[i / CPS] == CPS) || (cc == NC);
    it.tag = tag;
    q.push_back(it);
  endtask

  function automatic logic [2*NC-1:0] sv(input logic [NC-1:0] m, input logic [1:0] code,
                                          input logic [2*NC-1:0] base);
    for (int i = 0; i < NC; i++) if (m[i]) base[2*i +: 2] = code;
    return base;
  endfunction

  task automatic arrive(input logic [NC-1:0] m, input logic [1:0] code, input string tag);
    step(m, sv(m, code, '0), tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step('0, '0, tag);
  endtask

  initial begin
    cc = 0;
    for (int t = 0; t < NT; t++) tc[t] = 0;
    for (int g = 0; g < SGN; g++) sc[g] = 0;
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (wake !== '0) begin bad++; $display("FAIL R1 wake=%h expected=0", wake); end
    @(negedge clk); rst_n = 1;

    // R2: tile 0 one core per cycle; R6: pulse then quiet
    arrive(16'h0001, 2'd0, "R2"); arrive(16'h0002, 2'd0, "R2");
    arrive(16'h0004, 2'd0, "R2"); arrive(16'h0008, 2'd0, "R2");
    idle(3, "R6");
    // R10: reuse the same tile for a second round
    arrive(16'h0003, 2'd0, "R10"); arrive(16'h000C, 2'd0, "R10");
    idle(2, "R10");
    // R7: whole tile in one cycle
    arrive(16'h00F0, 2'd0, "R7");
    idle(2, "R7");
    // R3 / R5: subgroup 0 two cores at a time
    arrive(16'h0003, 2'd1, "R3"); arrive(16'h000C, 2'd1, "R3");
    arrive(16'h0030, 2'd1, "R5"); arrive(16'h00C0, 2'd1, "R5");
    idle(2, "R5");
    // R4: cluster
    arrive(16'h00FF, 2'd2, "R4"); arrive(16'hFF00, 2'd2, "R4");
    idle(2, "R4");
    // R9: reserved code ignored
    arrive(16'h0F00, 2'd3, "R9"); idle(1, "R9");
    arrive(16'h0700, 2'd0, "R9"); idle(1, "R9");
    arrive(16'h0800, 2'd0, "R9"); idle(2, "R9");
    // R8: arrival during wake cycle joins next round
    arrive(16'hF000, 2'd0, "R8");
    arrive(16'h1000, 2'd0, "R8");
    idle(1, "R8");
    arrive(16'hE000, 2'd0, "R8");
    idle(2, "R8");
    // R11: mixed scopes in one cycle
    step(16'hFFF0, sv(16'h0F00, 2'd1, sv(16'h00F0, 2'd2, sv(16'h0000, 2'd0, '0))), "R11");
    step(16'hF00F, sv(16'h000F, 2'd0, sv(16'hF000, 2'd1, '0)), "R11");
    idle(2, "R11");
    arrive(16'hFF0F, 2'd2, "R11");
    idle(3, "R11");

    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end
endmodule